// File: doc/BRIEF.md
# Tuple History Compressor for Stream Index Tokens

This block is a second compression stage for a sequence of stream-cache index tokens. It groups consecutive tokens into tuples of `TUPLE_N` tokens. Once a tuple is complete, the block stops taking input and searches a history table of earlier tuples. If the tuple is found, the block reports the table position where it sits. If it is not found, the block reports position zero, presents the whole tuple on a separate miss output, and stores the tuple in the table. The table is refilled in first-in, first-out order.

The search walks the table one position per cycle. It starts at position 1 and stops at the first live entry that matches. The time spent on a lookup therefore has a fixed upper bound. While the block is busy, `in_ready` is held low, so the token source waits. Each tuple produces exactly one result pulse. There is no handshake on the result side.

The controller has three states. `ST_FILL` takes tokens while the tuple is not full. The transition *fill-done* moves from `ST_FILL` to `ST_SCAN` once the tuple is full. `ST_SCAN` compares one table position per cycle. It leaves for `ST_REPORT` either by *scan-hit*, when a live entry matches, or by *scan-exhausted*, when position `DEPTH-1` has been compared without a match. `ST_REPORT` drives the result for one cycle, writes the table on a miss, clears the tuple, and returns to `ST_FILL` by *report-done*.

Top module: `ntc_top`

## Requirements
- R1: A tuple is made of `TUPLE_N` accepted tokens. The first accepted token sits in bits `[IDX_W-1:0]` of the tuple, and token i sits in bits `[i*IDX_W +: IDX_W]`. Tuples do not overlap, and the buffer is emptied after every result.
- R2: `in_ready` is high only in `ST_FILL` while the tuple is not yet full. A token offered while `in_ready` is low is not taken and does not appear in any tuple.
- R3: A lookup starts only after the tuple is full. Each tuple produces exactly one `res_valid` pulse, one cycle long.
- R4: On a hit, `res_pos` holds the lowest position p in the range 1 to `DEPTH-1` whose live entry equals the tuple, and `miss_valid` is low.
- R5: On a miss, `res_pos` is 0, `miss_valid` is high together with `res_valid`, and `miss_tuple` carries the full tuple.
- R6: Only a miss writes the table. The write goes to the FIFO write position, which starts at 1, advances by one per miss, and wraps from `DEPTH-1` back to 1, replacing the oldest entry. A hit leaves the table contents and the write position unchanged.
- R7: Say the last token of a tuple is taken at clock edge k. A hit at position p raises `res_valid` after edge k+1+p. A miss raises it after edge k+`DEPTH`.
- R8: After reset the table holds no live entries, `in_ready` is high, and `res_valid` and `miss_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A token is offered |
| in_tok | input | IDX_W | Token value |
| in_ready | output | 1 | The block takes a token this cycle |
| res_valid | output | 1 | One-cycle result pulse, one per tuple |
| res_pos | output | $clog2(DEPTH) | Matching position on a hit, 0 on a miss |
| miss_valid | output | 1 | The result is a miss |
| miss_tuple | output | IDX_W*TUPLE_N | The tuple that missed; zero otherwise |

## Verification
The bench builds the block with 2-bit tokens, two tokens per tuple, and `DEPTH` = 5, which gives four table positions. With these values all 16 possible tuples can be pushed through the table. The write position therefore wraps several times, and a hit can be produced at every position, so the exact latency for each position can be checked. A tuple stream drawn from a small alphabet mixes hits, misses and evictions, and every result is compared with an arithmetic FIFO model kept in the bench. Tokens offered during a scan check that input is ignored while `in_ready` is low.

// File: rtl/ntc_pkg.sv
package ntc_pkg;

    typedef enum logic [1:0] {
        ST_FILL   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_REPORT = 2'd2
    } ntc_state_e;

endpackage

// File: rtl/ntc_tuple_collect.sv
module ntc_tuple_collect #(
    parameter int IDX_W   = 8,
    parameter int TUPLE_N = 4,
    localparam int TUP_W  = IDX_W * TUPLE_N,
    localparam int CNT_W  = $clog2(TUPLE_N + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [IDX_W-1:0] tok,
    input  logic             clear,
    output logic             full,
    output logic [TUP_W-1:0] tuple
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(TUPLE_N);

    logic [CNT_W-1:0] fill_q;
    logic [IDX_W-1:0] lane_q [TUPLE_N];

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            fill_q <= '0;
        end else if (take) begin
            fill_q <= fill_q + 1'b1;
        end
    end

    for (genvar g = 0; g < TUPLE_N; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q[g] <= '0;
            end else if (take && fill_q == CNT_W'(g)) begin
                lane_q[g] <= tok;
            end
        end
        assign tuple[g*IDX_W +: IDX_W] = lane_q[g];
    end

    assign full = (fill_q == CNT_FULL);

    // R1: fill count never passes the tuple size
    p_fill_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= CNT_FULL);

    // R2: no token is taken once the tuple is full
    p_no_take_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !take);

endmodule

// File: rtl/ntc_history.sv
module ntc_history #(
    parameter int TUP_W = 32,
    parameter int DEPTH = 256,
    localparam int POS_W = $clog2(DEPTH),
    localparam int LAST  = DEPTH - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POS_W-1:0] rd_idx,
    output logic [TUP_W-1:0] rd_data,
    output logic             rd_live,
    input  logic             wr_en,
    input  logic [TUP_W-1:0] wr_data
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(LAST);
    localparam logic [POS_W-1:0] FIRST_POS = POS_W'(1);

    logic [TUP_W-1:0] slot_q [1:LAST];
    logic             live_q [1:LAST];
    logic [POS_W-1:0] wptr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= FIRST_POS;
        end else if (wr_en) begin
            wptr_q <= (wptr_q == LAST_POS) ? FIRST_POS : wptr_q + 1'b1;
        end
    end

    for (genvar s = 1; s <= LAST; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                live_q[s] <= 1'b0;
            end else if (wr_en && wptr_q == POS_W'(s)) begin
                live_q[s] <= 1'b1;
            end
        end
        always_ff @(posedge clk) begin
            if (wr_en && wptr_q == POS_W'(s)) begin
                slot_q[s] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        rd_live = 1'b0;
        if (rd_idx >= FIRST_POS && rd_idx <= LAST_POS) begin
            rd_data = slot_q[rd_idx];
            rd_live = live_q[rd_idx];
        end
    end

    // R6: write position stays inside 1..DEPTH-1
    p_wptr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wptr_q >= FIRST_POS && wptr_q <= LAST_POS);

    // R6: without a write the FIFO position does not move
    p_wptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(wptr_q));

endmodule

// File: rtl/ntc_scan_ctrl.sv
module ntc_scan_ctrl
    import ntc_pkg::*;
#(
    parameter int TUP_W = 32,
    parameter int DEPTH = 256,
    localparam int POS_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             full,
    input  logic [TUP_W-1:0] tuple,
    input  logic [TUP_W-1:0] rd_data,
    input  logic             rd_live,
    output logic [POS_W-1:0] rd_idx,
    output logic             in_ready,
    output logic             clear,
    output logic             wr_en,
    output logic             res_valid,
    output logic [POS_W-1:0] res_pos,
    output logic             miss_valid
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(DEPTH - 1);

    ntc_state_e       state_q;
    logic [POS_W-1:0] ptr_q;
    logic [POS_W-1:0] pos_q;
    logic             found_q;
    logic             match;

    assign match = rd_live && (rd_data == tuple);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
            ptr_q   <= '0;
            pos_q   <= '0;
            found_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_FILL: begin
                    if (full) begin
                        state_q <= ST_SCAN;          // fill-done
                        ptr_q   <= POS_W'(1);
                    end
                end
                ST_SCAN: begin
                    if (match) begin
                        state_q <= ST_REPORT;        // scan-hit
                        pos_q   <= ptr_q;
                        found_q <= 1'b1;
                    end else if (ptr_q == LAST_POS) begin
                        state_q <= ST_REPORT;        // scan-exhausted
                        pos_q   <= '0;
                        found_q <= 1'b0;
                    end else begin
                        ptr_q <= ptr_q + 1'b1;
                    end
                end
                ST_REPORT: begin
                    state_q <= ST_FILL;              // report-done
                end
                default: state_q <= ST_FILL;
            endcase
        end
    end

    always_comb begin
        in_ready   = 1'b0;
        clear      = 1'b0;
        wr_en      = 1'b0;
        res_valid  = 1'b0;
        res_pos    = '0;
        miss_valid = 1'b0;
        rd_idx     = ptr_q;
        unique case (state_q)
            ST_FILL:   in_ready = !full;
            ST_SCAN:   ;
            ST_REPORT: begin
                res_valid  = 1'b1;
                res_pos    = pos_q;
                miss_valid = !found_q;
                wr_en      = !found_q;
                clear      = 1'b1;
            end
            default:   ;
        endcase
    end

    // R3: a result is a single-cycle pulse
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R2: after a result the block is ready to collect again
    p_ready_after_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> in_ready);

    // R4: a hit reports a position inside 1..DEPTH-1
    p_hit_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !miss_valid) |-> (res_pos != '0 && res_pos <= LAST_POS));

    // R5: a miss reports position zero
    p_miss_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid |-> (res_valid && res_pos == '0));

    // R3: a scan starts from a full tuple
    p_scan_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN) |-> full);

endmodule

// File: rtl/ntc_top.sv
module ntc_top #(
    parameter int IDX_W   = 8,
    parameter int TUPLE_N = 4,
    parameter int DEPTH   = 256,
    localparam int TUP_W  = IDX_W * TUPLE_N,
    localparam int POS_W  = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IDX_W-1:0] in_tok,
    output logic             in_ready,
    output logic             res_valid,
    output logic [POS_W-1:0] res_pos,
    output logic             miss_valid,
    output logic [TUP_W-1:0] miss_tuple
);

    logic             take;
    logic             full;
    logic             clear;
    logic             wr_en;
    logic             rd_live;
    logic [TUP_W-1:0] tuple;
    logic [TUP_W-1:0] rd_data;
    logic [POS_W-1:0] rd_idx;

    assign take = in_valid && in_ready;

    ntc_tuple_collect #(.IDX_W(IDX_W), .TUPLE_N(TUPLE_N)) u_collect (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (take),
        .tok   (in_tok),
        .clear (clear),
        .full  (full),
        .tuple (tuple)
    );

    ntc_history #(.TUP_W(TUP_W), .DEPTH(DEPTH)) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .rd_live (rd_live),
        .wr_en   (wr_en),
        .wr_data (tuple)
    );

    ntc_scan_ctrl #(.TUP_W(TUP_W), .DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .full       (full),
        .tuple      (tuple),
        .rd_data    (rd_data),
        .rd_live    (rd_live),
        .rd_idx     (rd_idx),
        .in_ready   (in_ready),
        .clear      (clear),
        .wr_en      (wr_en),
        .res_valid  (res_valid),
        .res_pos    (res_pos),
        .miss_valid (miss_valid)
    );

    assign miss_tuple = miss_valid ? tuple : '0;

    // R5: the miss tuple is only driven alongside a miss
    p_tuple_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !miss_valid |-> (miss_tuple == '0));

endmodule

// File: tb/sim_ntc_top.sv
module sim_ntc_top;

    localparam int IDX_W   = 2;
    localparam int TUPLE_N = 2;
    localparam int DEPTH   = 5;
    localparam int LAST    = DEPTH - 1;
    localparam int POS_W   = $clog2(DEPTH);
    localparam int TUP_W   = IDX_W * TUPLE_N;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [IDX_W-1:0] in_tok = '0;
    logic             in_ready;
    logic             res_valid;
    logic [POS_W-1:0] res_pos;
    logic             miss_valid;
    logic [TUP_W-1:0] miss_tuple;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    int mslot [1:LAST];
    bit mlive [1:LAST];
    int mwp = 1;

    always #10 clk = ~clk;

    ntc_top #(.IDX_W(IDX_W), .TUPLE_N(TUPLE_N), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tok(in_tok),
        .in_ready(in_ready), .res_valid(res_valid), .res_pos(res_pos),
        .miss_valid(miss_valid), .miss_tuple(miss_tuple)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            errors++;
            $display("FAIL watchdog: actual cycles %0d expected < 50000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_tok(int v);
        in_valid = 1'b1;
        in_tok   = IDX_W'(v);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // sends tokens a then b; tuple value is a + b*4 (first token in low bits)
    task automatic send_tuple(int a, int b, bit poke, string req);
        int t;
        int epos;
        int elat;
        bit seen;
        t = a + (b << IDX_W);
        epos = 0;
        for (int s = 1; s <= LAST; s++)
            if (epos == 0 && mlive[s] && mslot[s] == t) epos = s;
        elat = (epos != 0) ? epos + 1 : LAST + 1;
        send_tok(a);
        send_tok(b);
        // R2: full tuple closes the input
        check("R2 ready low after full tuple", int'(in_ready), 0);
        if (poke) begin
            in_valid = 1'b1;
            in_tok   = IDX_W'(~a);
        end
        seen = 1'b0;
        for (int c = 1; c <= LAST + 3; c++) begin
            @(negedge clk);
            if (poke && c == 1) in_valid = 1'b0;
            if (res_valid) begin
                seen = 1'b1;
                check({req, " R7 latency"}, c, elat);
                check({req, " R4/R5 position"}, int'(res_pos), epos);
                check({req, " R5 miss flag"}, int'(miss_valid), (epos == 0) ? 1 : 0);
                if (epos == 0)
                    check({req, " R1 miss tuple"}, int'(miss_tuple), t);
                break;
            end
        end
        check({req, " R3 result seen"}, int'(seen), 1);
        @(negedge clk);
        check({req, " R3 pulse ends, ready back"}, int'(res_valid) + 2*int'(in_ready), 2);
        if (epos == 0) begin
            mslot[mwp] = t;
            mlive[mwp] = 1'b1;
            mwp = (mwp == LAST) ? 1 : mwp + 1;
        end
    endtask

    initial begin
        int seed;
        int t;
        for (int s = 1; s <= LAST; s++) begin
            mslot[s] = 0;
            mlive[s] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        check("R8 ready", int'(in_ready), 1);
        check("R8 res_valid", int'(res_valid), 0);
        check("R8 miss_valid", int'(miss_valid), 0);

        // R8/R6: empty table, all 16 tuples miss and wrap the FIFO four times
        for (int k = 0; k < 16; k++)
            send_tuple(k % 4, k / 4, 1'b0, "R6 fill sweep");
        // R4: hits at every position, table untouched by hits
        for (int k = 12; k < 16; k++)
            send_tuple(k % 4, k / 4, 1'b0, "R4 hit sweep");
        // R2: token offered during scan is ignored
        send_tuple(3, 3, 1'b1, "R2 poke hit");
        send_tuple(1, 0, 1'b1, "R2 poke miss");
        send_tuple(2, 3, 1'b0, "R6 hit after evict");
        send_tuple(0, 3, 1'b0, "R6 evicted tuple");
        // mixed stream from a small alphabet
        seed = 7;
        for (int k = 0; k < 150; k++) begin
            seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
            t = (seed >> 8) % 7;
            send_tuple(t % 4, t / 4, (k % 5) == 0, "R4/R6 mixed");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule